// File: doc/BRIEF.md
# Dual-Channel PWM Timer with Up/Down Counting

This block is an 8-bit timer that drives two waveform pins, A and B. A shared prescaler divides the system clock into timer ticks. On each tick the counter advances in one of three ways. It can wrap on a compare match (CTC), count up as a single slope and wrap at TOP (fast PWM), or count up to TOP and back down (phase-correct PWM). In the PWM modes with a programmable TOP, compare register A supplies TOP. Channel A in toggle mode then gives an exact 50% square wave at half the PWM rate, and channel B keeps an adjustable duty cycle.

Software programs the block through a small write-only register port. The port sets the waveform mode, the output action for each channel, the prescaler selection and the two compare values. In the PWM modes, compare writes go to a holding copy and reach the comparators only at a safe point in the count. In CTC mode they take effect at once.

Top module: `pwm_tmr`

## Requirements
- R1: Writes occur on a clock edge with `wr_en_i` high. Address 0 is control: bits [1:0] select the waveform mode, bits [3:2] the channel A action, bits [5:4] the channel B action. Address 1 bits [2:0] select the prescaler. Address 2 is compare A and address 3 is compare B.
- R2: Prescaler code 0 stops the timer, and the outputs then hold. Codes 1, 2, 3 and 4 give one tick per 1, 8, 64 and 256 clocks, and codes 5 to 7 give one tick per 1024 clocks. The outputs change only on a tick.
- R3: Mode 2 is phase-correct with TOP equal to compare A. Mode 3 is phase-correct with TOP equal to 255. The count runs 0 up to TOP and back down to 0, so one PWM period is 2×TOP ticks. On the tick that reaches TOP, the count equals the TOP in force.
- R4: Channel action code 1 toggles the pin each time the count enters the channel's compare value. In mode 2 channel A toggles once per period, giving a 50% square wave at half the PWM rate.
- R5: In the phase-correct modes, action code 2 (non-inverting) drives the pin high for 2×compare B ticks of each 2×TOP tick period, centred on count 0. Action code 3 drives the complement.
- R6: In phase-correct non-inverting mode with TOP above 0, compare B of 0 holds the pin low for the whole period. Compare B at or above TOP holds it high for the whole period.
- R7: Mode 1 is fast PWM: the count runs 0 to TOP = compare A and wraps. Non-inverting drives the pin high while the count is at or below the compare value. Toggle on channel A gives a square wave with a period of 2×(TOP+1) ticks, which is one clock per level when compare A is 0 and the prescaler code is 1.
- R8: Mode 0 is CTC: the count wraps after reaching compare A. Action code 2 clears the pin on a match and action code 3 sets it. Compare writes reach the comparators on the next clock.
- R9: In the PWM modes a compare write is held back. It takes effect after the tick on which the count reaches TOP in the phase-correct modes, or wraps to 0 in fast PWM. The pin level on that tick still uses the old value.
- R10: While `rst_ni` is low, the count is 0, the mode is CTC, the timer is stopped and both pins are low. Action code 0 drives the pin low on every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 8 | Register write data |
| wave_a_o | output | 1 | Channel A waveform |
| wave_b_o | output | 1 | Channel B waveform |

## Verification
In phase-correct mode, one tick can both reach TOP and load the held compare values, and channel B's pin level is decided on that same tick. The test writes a larger compare B just after pin B falls on the way up. It then checks that the pin stays low through the TOP tick, which is judged on the old value. The pin must rise on the first tick of the down slope, under the new value. The duty and edge counts taken over whole periods catch a level computed off by one tick at the turn points.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
  typedef enum logic [1:0] {
    WM_CTC        = 2'd0,
    WM_FAST       = 2'd1,
    WM_PHASE      = 2'd2,
    WM_PHASE_FULL = 2'd3
  } wave_mode_e;

  typedef enum logic [1:0] {
    CO_OFF    = 2'd0,
    CO_TOGGLE = 2'd1,
    CO_CLEAR  = 2'd2,
    CO_SET    = 2'd3
  } cmp_out_e;

  localparam int unsigned NUM_CH    = 2;
  localparam logic [1:0]  ADDR_CTRL = 2'd0;
  localparam logic [1:0]  ADDR_CLK  = 2'd1;
  localparam logic [1:0]  ADDR_CMPA = 2'd2;
  localparam logic [1:0]  ADDR_CMPB = 2'd3;
endpackage

// File: rtl/pwm_tmr_prescale.sv
module pwm_tmr_prescale #(
  parameter int unsigned PRE_W = 10,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned LOG_D8   = 3;
  localparam int unsigned LOG_D64  = 6;
  localparam int unsigned LOG_D256 = 8;

  logic [PRE_W-1:0] pre_q;

  function automatic logic [PRE_W-1:0] low_mask(input int unsigned n);
    low_mask = PRE_W'((64'd1 << n) - 64'd1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + 1'b1;
  end

  // tick when the low n bits of the free-running count are all ones
  always_comb begin
    case (sel_i)
      SEL_W'(0): tick_o = 1'b0;
      SEL_W'(1): tick_o = 1'b1;
      SEL_W'(2): tick_o = &(pre_q | ~low_mask(LOG_D8));
      SEL_W'(3): tick_o = &(pre_q | ~low_mask(LOG_D64));
      SEL_W'(4): tick_o = &(pre_q | ~low_mask(LOG_D256));
      default:   tick_o = &pre_q;
    endcase
  end
endmodule

// File: rtl/pwm_tmr_counter.sv
module pwm_tmr_counter
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  wave_mode_e       mode_i,
  input  logic [CNT_W-1:0] top_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             down_o,
  output logic [CNT_W-1:0] nxt_cnt_o,
  output logic             nxt_down_o,
  output logic             at_top_o,
  output logic             at_bottom_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             down_q;
  logic [CNT_W:0]   inc;

  assign inc = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    nxt_cnt_o   = cnt_q;
    nxt_down_o  = down_q;
    at_top_o    = 1'b0;
    at_bottom_o = 1'b0;
    if (mode_i == WM_PHASE || mode_i == WM_PHASE_FULL) begin
      if (!down_q) begin
        if (inc >= {1'b0, top_i}) begin
          nxt_cnt_o  = top_i;
          nxt_down_o = 1'b1;
          at_top_o   = 1'b1;
        end else begin
          nxt_cnt_o = inc[CNT_W-1:0];
        end
      end else if (cnt_q <= CNT_W'(1)) begin
        nxt_cnt_o  = '0;
        nxt_down_o = 1'b0;
      end else begin
        nxt_cnt_o = cnt_q - 1'b1;
      end
    end else begin
      nxt_down_o = 1'b0;
      if (cnt_q >= top_i) begin
        nxt_cnt_o   = '0;
        at_bottom_o = 1'b1;
      end else begin
        nxt_cnt_o = inc[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (tick_i) begin
      cnt_q  <= nxt_cnt_o;
      down_q <= nxt_down_o;
    end
  end

  assign cnt_o  = cnt_q;
  assign down_o = down_q;
endmodule

// File: rtl/pwm_tmr_channel.sv
module pwm_tmr_channel
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  wave_mode_e       mode_i,
  input  cmp_out_e         com_i,
  input  logic [CNT_W-1:0] nxt_cnt_i,
  input  logic             nxt_down_i,
  input  logic [CNT_W-1:0] ocr_i,
  output logic             wave_o
);
  logic wave_q, wave_d, match, lvl, is_pwm;

  // pin is a registered function of the state the counter enters
  always_comb begin
    match  = (nxt_cnt_i == ocr_i);
    is_pwm = (mode_i != WM_CTC);
    case (mode_i)
      WM_FAST:                lvl = (nxt_cnt_i <= ocr_i);
      WM_PHASE, WM_PHASE_FULL: lvl = nxt_down_i ? (nxt_cnt_i <= ocr_i) : (nxt_cnt_i < ocr_i);
      default:                lvl = 1'b0;
    endcase
    case (com_i)
      CO_TOGGLE: wave_d = wave_q ^ match;
      CO_CLEAR:  wave_d = is_pwm ? lvl  : (wave_q & ~match);
      CO_SET:    wave_d = is_pwm ? ~lvl : (wave_q | match);
      default:   wave_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wave_q <= 1'b0;
    else if (tick_i) wave_q <= wave_d;
  end

  assign wave_o = wave_q;
endmodule

// File: rtl/pwm_tmr.sv
module pwm_tmr
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned PRE_W  = 10,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic              wave_a_o,
  output logic              wave_b_o
);
  wave_mode_e       mode_q;
  cmp_out_e         com_q    [NUM_CH];
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] shadow_q [NUM_CH];
  logic [CNT_W-1:0] active_q [NUM_CH];
  logic [NUM_CH-1:0] wave;

  logic             tick, at_top, at_bottom, down, nxt_down, load, is_phase;
  logic [CNT_W-1:0] cnt, nxt_cnt, top_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= WM_CTC;
      sel_q  <= '0;
      for (int c = 0; c < NUM_CH; c++) begin
        com_q[c]    <= CO_OFF;
        shadow_q[c] <= '0;
      end
    end else if (wr_en_i) begin
      case (wr_addr_i)
        ADDR_W'(ADDR_CTRL): begin
          mode_q   <= wave_mode_e'(wr_data_i[1:0]);
          com_q[0] <= cmp_out_e'(wr_data_i[3:2]);
          com_q[1] <= cmp_out_e'(wr_data_i[5:4]);
        end
        ADDR_W'(ADDR_CLK):  sel_q       <= wr_data_i[SEL_W-1:0];
        ADDR_W'(ADDR_CMPA): shadow_q[0] <= wr_data_i;
        default:            shadow_q[1] <= wr_data_i;
      endcase
    end
  end

  assign is_phase = (mode_q == WM_PHASE) || (mode_q == WM_PHASE_FULL);
  assign top_val  = (mode_q == WM_PHASE_FULL) ? '1 : active_q[0];
  // CTC copies every clock; PWM modes copy at TOP (phase) or BOTTOM (fast)
  assign load = (mode_q == WM_CTC) ||
                (tick && ((is_phase && at_top) || (mode_q == WM_FAST && at_bottom)));

  pwm_tmr_prescale #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel_q),
    .tick_o (tick)
  );

  pwm_tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .mode_i      (mode_q),
    .top_i       (top_val),
    .cnt_o       (cnt),
    .down_o      (down),
    .nxt_cnt_o   (nxt_cnt),
    .nxt_down_o  (nxt_down),
    .at_top_o    (at_top),
    .at_bottom_o (at_bottom)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   active_q[g] <= '0;
      else if (load) active_q[g] <= shadow_q[g];
    end

    pwm_tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick),
      .mode_i     (mode_q),
      .com_i      (com_q[g]),
      .nxt_cnt_i  (nxt_cnt),
      .nxt_down_i (nxt_down),
      .ocr_i      (active_q[g]),
      .wave_o     (wave[g])
    );
  end

  assign wave_a_o = wave[0];
  assign wave_b_o = wave[1];
endmodule

// File: rtl/pwm_tmr_chk.sv
module pwm_tmr_chk
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input wave_mode_e       mode_i,
  input cmp_out_e         com_a_i,
  input cmp_out_e         com_b_i,
  input logic [CNT_W-1:0] ocr_b_i,
  input logic [CNT_W-1:0] top_i,
  input logic             at_top_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             down_i,
  input logic             wave_a_i,
  input logic             wave_b_i
);
  assert_hold_no_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(wave_a_i) && $stable(wave_b_i)));

  assert_off_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && com_a_i == CO_OFF) |=> !wave_a_i);

  assert_zero_duty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mode_i == WM_PHASE && com_b_i == CO_CLEAR && ocr_b_i == '0 && top_i != '0)
      |=> !wave_b_i);

  assert_fast_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mode_i == WM_FAST && com_b_i == CO_CLEAR && ocr_b_i >= top_i) |=> wave_b_i);

  assert_reach_top_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && (mode_i == WM_PHASE || mode_i == WM_PHASE_FULL) && at_top_i)
      |=> (cnt_i == $past(top_i) && down_i));
endmodule

bind pwm_tmr pwm_tmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick),
  .mode_i   (mode_q),
  .com_a_i  (com_q[0]),
  .com_b_i  (com_q[1]),
  .ocr_b_i  (active_q[1]),
  .top_i    (top_val),
  .at_top_i (at_top),
  .cnt_i    (cnt),
  .down_i   (down),
  .wave_a_i (wave_a_o),
  .wave_b_i (wave_b_o)
);

// File: tb/tb_pwm_tmr.sv
module tb_pwm_tmr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       wave_a, wave_b;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  pwm_tmr dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .wave_a_o  (wave_a),
    .wave_b_o  (wave_b)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [1:0]  com_a;
    logic [1:0]  com_b;
    logic [2:0]  sel;
    logic [7:0]  cmp_a;
    logic [7:0]  cmp_b;
    logic [15:0] warm;
    logic [15:0] win;
    logic [15:0] hi_a;
    logic [15:0] rise_a;
    logic [15:0] hi_b;
    logic [15:0] rise_b;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd2, 2'd1, 2'd2, 3'd1, 8'd10, 8'd3,  16'd80,   16'd400,  16'd200,  16'd10,  16'd120, 16'd20},
    '{2'd2, 2'd0, 2'd3, 3'd1, 8'd10, 8'd3,  16'd80,   16'd400,  16'd0,    16'd0,   16'd280, 16'd20},
    '{2'd2, 2'd1, 2'd2, 3'd1, 8'd10, 8'd0,  16'd80,   16'd400,  16'd200,  16'd10,  16'd0,   16'd0},
    '{2'd2, 2'd1, 2'd2, 3'd1, 8'd10, 8'd12, 16'd80,   16'd400,  16'd200,  16'd10,  16'd400, 16'd0},
    '{2'd1, 2'd1, 2'd2, 3'd1, 8'd9,  8'd4,  16'd40,   16'd400,  16'd200,  16'd20,  16'd200, 16'd40},
    '{2'd1, 2'd1, 2'd0, 3'd1, 8'd0,  8'd0,  16'd10,   16'd400,  16'd200,  16'd200, 16'd0,   16'd0},
    '{2'd0, 2'd1, 2'd1, 3'd1, 8'd7,  8'd3,  16'd40,   16'd400,  16'd200,  16'd25,  16'd200, 16'd25},
    '{2'd0, 2'd0, 2'd2, 3'd1, 8'd7,  8'd3,  16'd40,   16'd400,  16'd0,    16'd0,   16'd0,   16'd0},
    '{2'd0, 2'd0, 2'd3, 3'd1, 8'd7,  8'd3,  16'd40,   16'd400,  16'd0,    16'd0,   16'd400, 16'd0},
    '{2'd2, 2'd1, 2'd2, 3'd3, 8'd4,  8'd1,  16'd2100, 16'd2048, 16'd1024, 16'd2,   16'd512, 16'd4},
    '{2'd3, 2'd0, 2'd2, 3'd1, 8'd10, 8'd64, 16'd1100, 16'd1020, 16'd0,    16'd0,   16'd256, 16'd2}
  };

  function automatic string vtag(input int i);
    case (i)
      0:       vtag = "R1 R3 R4 R5";
      1:       vtag = "R5 R10";
      2, 3:    vtag = "R6";
      4, 5:    vtag = "R7";
      6, 7, 8: vtag = "R8";
      9:       vtag = "R2 R4";
      default: vtag = "R3 R5";
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic setup(input vec_t v);
    do_reset();
    wr(2'd2, v.cmp_a);
    wr(2'd3, v.cmp_b);
    wr(2'd0, {2'b00, v.com_b, v.com_a, v.mode});
    wr(2'd1, {5'b0, v.sel});
  endtask

  task automatic run_vec(input int idx);
    vec_t v;
    int ha, ra, hb, rb;
    logic pa, pb;
    v = VECS[idx];
    ha = 0; ra = 0; hb = 0; rb = 0;
    setup(v);
    repeat (int'(v.warm)) @(negedge clk);
    pa = wave_a;
    pb = wave_b;
    for (int i = 0; i < int'(v.win); i++) begin
      @(negedge clk);
      if (wave_a) ha++;
      if (wave_b) hb++;
      if (wave_a && !pa) ra++;
      if (wave_b && !pb) rb++;
      pa = wave_a;
      pb = wave_b;
    end
    check(vtag(idx), $sformatf("vec%0d A high", idx), ha, int'(v.hi_a));
    check(vtag(idx), $sformatf("vec%0d A rises", idx), ra, int'(v.rise_a));
    check(vtag(idx), $sformatf("vec%0d B high", idx), hb, int'(v.hi_b));
    check(vtag(idx), $sformatf("vec%0d B rises", idx), rb, int'(v.rise_b));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL R2 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic prev;
    int lows;
    bit found;

    // R10: reset state
    repeat (2) @(negedge clk);
    check("R10", "A in reset", int'(wave_a), 0);
    check("R10", "B in reset", int'(wave_b), 0);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R2: prescaler code 0 keeps the timer stopped
    do_reset();
    wr(2'd2, 8'd3);
    wr(2'd3, 8'd1);
    wr(2'd0, {2'b00, 2'd1, 2'd1, 2'd0});
    repeat (50) @(negedge clk);
    check("R2", "A while stopped", int'(wave_a), 0);
    check("R2", "B while stopped", int'(wave_b), 0);

    // R9: compare B write mid-period held until TOP in phase-correct mode
    do_reset();
    wr(2'd2, 8'd10);
    wr(2'd3, 8'd5);
    wr(2'd0, {2'b00, 2'd2, 2'd0, 2'd2});
    wr(2'd1, 8'd1);
    repeat (60) @(negedge clk);
    prev  = wave_b;
    found = 1'b0;
    for (int i = 0; i < 100 && !found; i++) begin
      @(negedge clk);
      if (prev && !wave_b) found = 1'b1;
      prev = wave_b;
    end
    check("R9", "B falling edge seen", int'(found), 1);
    wr_en   = 1'b1;
    wr_addr = 2'd3;
    wr_data = 8'd9;
    @(negedge clk);
    wr_en = 1'b0;
    lows  = 0;
    for (int i = 0; i < 5; i++) begin
      if (!wave_b) lows++;
      if (i < 4) @(negedge clk);
    end
    check("R9", "B low until TOP with old compare", lows, 5);
    @(negedge clk);
    check("R9", "B high after TOP with new compare", int'(wave_b), 1);

    // R10: asynchronous reset clears the pins at once
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10", "A after reset", int'(wave_a), 0);
    check("R10", "B after reset", int'(wave_b), 0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule